// File: doc/BRIEF.md
# PLL Control Register Block with Feed-Gated Updates

This block sits between a register bus and an external clock-multiplier PLL. Software writes a control register, which holds the enable and connect bits, and a configuration register, which holds the multiplier (MSEL) and divider (PSEL) fields. These writes land in shadow copies only. The PLL-facing outputs take the shadow values only after a two-write unlock on an 8-bit feed register: the byte 0xAA, then the byte 0x55 on the very next bus write.

A power-down request clears enable and connect at once. Wake-up does not bring them back: software must write them again and then issue a new feed. Connect toward the PLL is granted only while the active enable bit is set and the lock input is high. Because of this, software enables the PLL with one feed, polls the lock flag in the status register, and connects with a second feed. The status register reports the active values and the live lock flag. It never reports the shadow values.

Top module: `pll_feed_ctrl`

## Requirements
- R1: After reset, `pll_enable`, `pll_connect`, `pll_msel` and `pll_psel` are zero. A status read returns 0, and a read of the feed address (2) returns 0.
- R2: Writes to the control address (0) or the configuration address (1) leave all PLL outputs unchanged until a valid feed.
- R3: A write of 0xAA to the feed address (2), followed on the next bus write by 0x55 to the same address, copies the shadow values to the active registers. The outputs show the new values in the cycle after the 0x55 write is sampled.
- R4: If any other bus write comes between 0xAA and 0x55, the sequence is aborted. The pending values stay pending, and a later correct feed applies them.
- R5: If the write after 0xAA is any byte other than 0x55, the sequence is aborted and the outputs do not change.
- R6: `pll_connect` is high only while the active enable bit, the active connect bit and `pll_lock` are all set. If one feed applies both enable and connect while lock is low, connect stays low and rises in the cycle after lock is sampled high.
- R7: When `pll_lock` falls, `pll_connect` is low in the cycle after lock is sampled low.
- R8: When `pd_req` is sampled high, `pll_enable` and `pll_connect` are low from the next cycle on. MSEL and PSEL keep their active values.
- R9: After `pd_req` falls, enable and connect stay low, even if a bare feed is issued. They return only after the control register is written again and then fed.
- R10: A read of the status address (3) returns its data one cycle later, with the following layout: MSEL in bits 4:0, PSEL in bits 6:5, the active enable bit in bit 8, the active connect bit in bit 9, and the sampled lock in bit 10. Shadow values never appear in it.
- R11: Configuration write data places MSEL in bits 4:0 and PSEL in bits 6:5. Control write data places enable in bit 0 and connect in bit 1.
- R12: A feed issued while `pd_req` is high sets neither enable nor connect. Control writes made during power-down are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Write address: 0 control, 1 configuration, 2 feed |
| bus_wdata | input | 8 | Write data |
| bus_rd_addr | input | 2 | Read address, 3 selects status |
| bus_rdata | output | RDW | Registered read data |
| pll_lock | input | 1 | Lock indication from the PLL |
| pd_req | input | 1 | Power-down request |
| pll_enable | output | 1 | PLL enable toward the PLL |
| pll_connect | output | 1 | Connect PLL output as clock source |
| pll_msel | output | MW | Active multiplier field |
| pll_psel | output | PW | Active divider field |

## Verification
Every PLL-facing output and every read result is registered. A feed, a power-down request or a lock change therefore shows at the ports exactly one clock after the stimulus is sampled. Read data likewise arrives one clock after the read address is sampled.

The driver task applies each stimulus before a rising edge. Only after that edge has passed does it push the expected value into the scoreboard queue, and the monitor compares it on the following falling edge. Each check therefore samples the one cycle in which the result is due, and no check looks before that cycle or after it.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CFG  = 2'd1,
    A_FEED = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  localparam logic [7:0] UNLOCK_FIRST  = 8'hAA;
  localparam logic [7:0] UNLOCK_SECOND = 8'h55;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CONN_BIT = 1;
endpackage

// File: rtl/pllc_feed_seq.sv
module pllc_feed_seq
  import pllc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic       feed_ok
);
  logic armed_q;
  logic feed_hit;

  assign feed_hit = wr && (addr == A_FEED);
  assign feed_ok  = feed_hit && armed_q && (wdata == UNLOCK_SECOND);

  // Any bus write re-evaluates the arm state: only a first-key feed keeps it set.
  always_ff @(posedge clk) begin
    if (rst)     armed_q <= 1'b0;
    else if (wr) armed_q <= feed_hit && (wdata == UNLOCK_FIRST);
  end

  // R4
  arm_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(wr && addr == A_FEED && wdata == UNLOCK_FIRST));
endmodule

// File: rtl/pllc_regs.sv
module pllc_regs #(
  parameter int MW = 5,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_cfg,
  input  logic          wd_en,
  input  logic          wd_conn,
  input  logic [MW-1:0] wd_m,
  input  logic [PW-1:0] wd_p,
  input  logic          feed_ok,
  input  logic          pd_req,
  input  logic          lock,
  output logic          act_en,
  output logic          act_conn,
  output logic [MW-1:0] act_m,
  output logic [PW-1:0] act_p,
  output logic          conn_out
);
  logic          sh_en, sh_conn;
  logic [MW-1:0] sh_m;
  logic [PW-1:0] sh_p;
  logic          nxt_en, nxt_conn;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_en   <= 1'b0;
      sh_conn <= 1'b0;
      sh_m    <= '0;
      sh_p    <= '0;
    end else begin
      if (wr_ctrl) begin
        sh_en   <= wd_en;
        sh_conn <= wd_conn;
      end
      if (wr_cfg) begin
        sh_m <= wd_m;
        sh_p <= wd_p;
      end
      if (pd_req) begin
        sh_en   <= 1'b0;
        sh_conn <= 1'b0;
      end
    end
  end

  always_comb begin
    nxt_en   = act_en;
    nxt_conn = act_conn;
    if (feed_ok) begin
      nxt_en   = sh_en;
      nxt_conn = sh_conn;
    end
    if (pd_req) begin
      nxt_en   = 1'b0;
      nxt_conn = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_en   <= 1'b0;
      act_conn <= 1'b0;
      act_m    <= '0;
      act_p    <= '0;
      conn_out <= 1'b0;
    end else begin
      act_en   <= nxt_en;
      act_conn <= nxt_conn;
      if (feed_ok) begin
        act_m <= sh_m;
        act_p <= sh_p;
      end
      conn_out <= nxt_en && nxt_conn && lock;
    end
  end

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(feed_ok) |-> ($stable(act_m) && $stable(act_p)));
endmodule

// File: rtl/pllc_status.sv
module pllc_status #(
  parameter int MW  = 5,
  parameter int PW  = 2,
  parameter int RDW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     rd_addr,
  input  logic           act_en,
  input  logic           act_conn,
  input  logic [MW-1:0]  act_m,
  input  logic [PW-1:0]  act_p,
  input  logic           lock,
  output logic [RDW-1:0] rd_data
);
  import pllc_pkg::*;
  localparam int FLAG_BASE = 8 * ((MW + PW + 7) / 8);
  localparam int ST_EN     = FLAG_BASE;
  localparam int ST_CONN   = FLAG_BASE + 1;
  localparam int ST_LOCK   = FLAG_BASE + 2;

  logic [RDW-1:0] stat_word;

  always_comb begin
    stat_word = '0;
    stat_word[MW-1:0]     = act_m;
    stat_word[MW+PW-1:MW] = act_p;
    stat_word[ST_EN]      = act_en;
    stat_word[ST_CONN]    = act_conn;
    stat_word[ST_LOCK]    = lock;
  end

  always_ff @(posedge clk) begin
    if (rst)                      rd_data <= '0;
    else if (rd_addr == A_STAT)   rd_data <= stat_word;
    else                          rd_data <= '0;
  end

  // R10
  stat_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_addr == A_STAT) |-> (rd_data[ST_LOCK] == $past(lock)));
endmodule

// File: rtl/pll_feed_ctrl.sv
module pll_feed_ctrl #(
  parameter int MW  = 5,
  parameter int PW  = 2,
  parameter int RDW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_wr,
  input  logic [1:0]     bus_addr,
  input  logic [7:0]     bus_wdata,
  input  logic [1:0]     bus_rd_addr,
  output logic [RDW-1:0] bus_rdata,
  input  logic           pll_lock,
  input  logic           pd_req,
  output logic           pll_enable,
  output logic           pll_connect,
  output logic [MW-1:0]  pll_msel,
  output logic [PW-1:0]  pll_psel
);
  import pllc_pkg::*;

  logic feed_ok;
  logic act_conn_bit;
  logic wr_ctrl, wr_cfg;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_cfg  = bus_wr && (bus_addr == A_CFG);

  pllc_feed_seq u_feed (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .feed_ok (feed_ok)
  );

  pllc_regs #(.MW(MW), .PW(PW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_ctrl  (wr_ctrl),
    .wr_cfg   (wr_cfg),
    .wd_en    (bus_wdata[CTRL_EN_BIT]),
    .wd_conn  (bus_wdata[CTRL_CONN_BIT]),
    .wd_m     (bus_wdata[MW-1:0]),
    .wd_p     (bus_wdata[MW+PW-1:MW]),
    .feed_ok  (feed_ok),
    .pd_req   (pd_req),
    .lock     (pll_lock),
    .act_en   (pll_enable),
    .act_conn (act_conn_bit),
    .act_m    (pll_msel),
    .act_p    (pll_psel),
    .conn_out (pll_connect)
  );

  pllc_status #(.MW(MW), .PW(PW), .RDW(RDW)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .rd_addr  (bus_rd_addr),
    .act_en   (pll_enable),
    .act_conn (act_conn_bit),
    .act_m    (pll_msel),
    .act_p    (pll_psel),
    .lock     (pll_lock),
    .rd_data  (bus_rdata)
  );

  // R6
  conn_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    pll_connect |-> pll_enable);
  // R7
  conn_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    pll_connect |-> $past(pll_lock));
  // R8
  pd_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pd_req) |-> (!pll_enable && !pll_connect));
endmodule

// File: tb/sim_pll_feed_ctrl.sv
module sim_pll_feed_ctrl;
  localparam int PERIOD = 10;
  localparam int MW = 5, PW = 2, RDW = 16;

  logic clk = 1'b0;
  logic rst, bus_wr, pll_lock, pd_req;
  logic [1:0] bus_addr, bus_rd_addr;
  logic [7:0] bus_wdata;
  logic [RDW-1:0] bus_rdata;
  logic pll_enable, pll_connect;
  logic [MW-1:0] pll_msel;
  logic [PW-1:0] pll_psel;

  always #(PERIOD/2) clk = ~clk;

  pll_feed_ctrl #(.MW(MW), .PW(PW), .RDW(RDW)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd_addr(bus_rd_addr), .bus_rdata(bus_rdata),
    .pll_lock(pll_lock), .pd_req(pd_req), .pll_enable(pll_enable),
    .pll_connect(pll_connect), .pll_msel(pll_msel), .pll_psel(pll_psel)
  );

  typedef struct {
    string       req;
    bit          is_read;
    logic [15:0] exp;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Monitor: pops due items on the falling edge and compares.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      act = '0;
      if (it.is_read) act = bus_rdata;
      else begin
        act[4:0] = pll_msel;
        act[6:5] = pll_psel;
        act[8]   = pll_enable;
        act[9]   = pll_connect;
      end
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s %s actual=%h expected=%h", it.req,
                 it.is_read ? "read" : "outputs", act, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic feed();
    wr(2'd2, 8'hAA);
    wr(2'd2, 8'h55);
  endtask

  task automatic set_lock(input logic v);
    @(negedge clk); pll_lock = v;
    @(posedge clk); #1;
  endtask

  task automatic set_pd(input logic v);
    @(negedge clk); pd_req = v;
    @(posedge clk); #1;
  endtask

  // Expected layout: msel 4:0, psel 6:5, enable 8, connect 9.
  task automatic expect_out(input string r, input logic [15:0] e);
    item_t it;
    it.req = r; it.is_read = 1'b0; it.exp = e;
    sb.push_back(it);
  endtask

  task automatic expect_read(input string r, input logic [1:0] a, input logic [15:0] e);
    item_t it;
    @(negedge clk); bus_rd_addr = a;
    @(posedge clk); #1;
    it.req = r; it.is_read = 1'b1; it.exp = e;
    sb.push_back(it);
  endtask

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_rd_addr = '0; pll_lock = 1'b0; pd_req = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    expect_out("R1", 16'h000);
    expect_read("R1", 2'd3, 16'h000);
    expect_read("R1", 2'd2, 16'h000);

    wr(2'd1, 8'h2A);                 // m=10 p=1
    wr(2'd0, 8'h01);                 // enable
    expect_out("R2", 16'h000);
    wr(2'd2, 8'hAA);
    expect_out("R3", 16'h000);
    wr(2'd2, 8'h55);
    expect_out("R3", 16'h12A);
    expect_read("R10", 2'd3, 16'h12A);

    wr(2'd1, 8'h7F);                 // R11: m=31 p=3
    feed();
    expect_out("R11", 16'h17F);
    set_lock(1'b1);
    expect_read("R10", 2'd3, 16'h57F);

    wr(2'd0, 8'h03);
    wr(2'd2, 8'hAA);
    wr(2'd1, 8'h7F);                 // intervening write aborts
    wr(2'd2, 8'h55);
    expect_out("R4", 16'h17F);
    feed();
    expect_out("R4", 16'h37F);
    expect_read("R10", 2'd3, 16'h77F);

    wr(2'd0, 8'h01);
    wr(2'd2, 8'hAA);
    wr(2'd2, 8'h56);
    expect_out("R5", 16'h37F);
    feed();
    expect_out("R5", 16'h17F);

    set_lock(1'b0);
    wr(2'd0, 8'h03);
    feed();
    expect_out("R6", 16'h17F);
    expect_read("R6", 2'd3, 16'h37F);
    set_lock(1'b1);
    expect_out("R6", 16'h37F);

    set_lock(1'b0);
    expect_out("R7", 16'h17F);
    set_lock(1'b1);
    expect_out("R7", 16'h37F);

    wr(2'd1, 8'h05);
    expect_out("R2", 16'h37F);

    set_pd(1'b1);
    expect_out("R8", 16'h07F);
    wr(2'd0, 8'h03);
    feed();
    expect_out("R12", 16'h005);
    set_pd(1'b0);
    expect_out("R9", 16'h005);
    feed();
    expect_out("R9", 16'h005);
    wr(2'd0, 8'h03);
    feed();
    expect_out("R9", 16'h305);
    expect_read("R10", 2'd3, 16'h705);

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule